// File: doc/BRIEF.md
# Differential History Pattern Predictor

This block predicts the memory addresses a task will touch before it touches any of them. Each finished task is reduced by upstream logic to a differential vector: one signed delta per position, the difference between its ordered address set and the set of the task before it. Each distinct vector gets a short identifier from a small dictionary. The identifiers of the last few vectors form a history, and that history indexes a pattern table. Each table entry names the vector that followed the same history the last time it was seen.

When a task starts, the block reads the table entry for the current history. If the entry is valid, it streams out one predicted address per cycle. Each address is the address stored at that position for the previous task plus the predicted delta at the same position. When a task ends, the block looks up the observed vector in the dictionary and writes its identifier into the table entry for the old history. It then shifts that identifier into the history. A vector not yet in the dictionary replaces the least recently used entry. This suits workloads whose tasks repeat whole vectors in a fixed rhythm, such as A, A, B, A, A, B.

Top module: `dhp_predictor`

## Requirements
- R1: After reset, `pred_valid` is low, every table entry is invalid, every dictionary entry is empty and the history holds identifier 0 in every slot.
- R2: A `task_start` pulse taken while no stream is running and `task_end` is low reads the table entry for the current history. If that entry is valid, the first beat appears on the cycle after the pulse. If it is invalid, no beat appears.
- R3: A stream has exactly NPOS beats on consecutive cycles. `pred_pos` runs 0, 1, …, NPOS-1, and `pred_last` is high only on the beat with position NPOS-1.
- R4: The beat at position p carries the address at position p of the stored previous set plus the delta at position p of the predicted vector, modulo 2^ADDR_W. Position p occupies bits [p*ADDR_W +: ADDR_W] of both `end_diff` and `end_addrs`, and deltas are two's complement.
- R5: A `task_end` taken while idle writes the identifier of `end_diff` into the table entry for the history as it was before the pulse, and marks that entry valid. The history then shifts left by one identifier, with the newest identifier in its low bits. A vector already in the dictionary keeps its identifier.
- R6: A vector not yet in the dictionary takes the least recently used identifier and replaces the vector stored there. Both a match and an allocation make that identifier the most recently used. Starting from reset, the identifiers are handed out in the order 0, 1, 2, ….
- R7: A `task_end` taken while idle stores `end_addrs` as the previous set that later predictions add their deltas to.
- R8: While a stream is running, `task_start` and `task_end` are ignored. The stream is not restarted, and the table, history, dictionary and previous set keep their values.
- R9: A `task_start` in the same cycle as `task_end` is ignored, and the `task_end` is taken.
- R10: The history spans the last X identifiers. With X=2, the training sequence A, A, B, A, A, B gives A after history (B, A), A after history (A, B), and B after history (A, A).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| task_start | input | 1 | One-cycle pulse: a task begins, so request a prediction |
| task_end | input | 1 | One-cycle pulse: a task finished; `end_diff` and `end_addrs` are valid |
| end_diff | input | NPOS*ADDR_W | Observed differential vector of the finished task, position 0 in the low bits |
| end_addrs | input | NPOS*ADDR_W | Ordered address set of the finished task, position 0 in the low bits |
| pred_valid | output | 1 | A predicted address is presented this cycle |
| pred_pos | output | POS_W | Position of the current predicted address |
| pred_addr | output | ADDR_W | Predicted address |
| pred_last | output | 1 | This beat is the last of the stream |

## Verification
On every cycle, the assertions check the shape of the stream: it starts at position 0 on the cycle after an accepted start, its positions climb by one, and it stops right after the last beat. They also check that no training slips in while a stream runs, that the newest identifier lands in the low bits of the history, that at most one dictionary entry matches a vector, and that exactly one identifier is the oldest. Only the bench scenarios show which vector is predicted. That covers learning the A, A, B rhythm through a two-deep history, the address sums including negative deltas that wrap, the least recently used eviction seen through a stale table entry that now names the new vector, and the fact that pulses during a stream change nothing.

// File: rtl/dhp_pkg.sv
// Package: shared helpers for the differential history pattern predictor.
// Assumes: nothing beyond IEEE 1800-2017 constant functions.
package dhp_pkg;

    // Width of an index into n items, never less than one bit.
    function automatic int unsigned idx_bits(input int unsigned n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/dhp_dict.sv
// Module: vector dictionary with least-recently-used replacement.
// Maps a differential vector to a short identifier. A match returns the
// stored identifier; a miss returns the oldest identifier, which the entry
// takes on training. Ages form a permutation of 0..D-1, with D-1 the oldest.
// Assumes: D is a power of two and train only pulses when the caller
// accepts a task end.
module dhp_dict #(
    parameter int unsigned NPOS = 4,
    parameter int unsigned DW   = 32,
    parameter int unsigned D    = 4,
    parameter int unsigned IDW  = 2,
    parameter int unsigned PW   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              train,
    input  logic [NPOS*DW-1:0] vec_in,
    output logic [IDW-1:0]    train_id,
    input  logic [IDW-1:0]    rd_id,
    input  logic [PW-1:0]     rd_pos,
    output logic [DW-1:0]     rd_delta
);
    localparam int unsigned VW = NPOS * DW;

    logic [VW-1:0]  vecs [D];
    logic [D-1:0]   vld;
    logic [IDW-1:0] age  [D];
    logic [D-1:0]   match;
    logic [D-1:0]   oldest;
    logic           hit;
    logic [IDW-1:0] hit_id;
    logic [IDW-1:0] victim_id;

    // Per-entry compare and oldest flag.
    for (genvar i = 0; i < D; i++) begin : g_ent
        assign match[i]  = vld[i] && (vecs[i] == vec_in);
        assign oldest[i] = (age[i] == IDW'(D - 1));
    end

    // Encode the matching entry and the replacement victim.
    always_comb begin
        hit_id    = '0;
        victim_id = '0;
        for (int i = 0; i < D; i++) begin
            if (match[i])  hit_id    = IDW'(i);
            if (oldest[i]) victim_id = IDW'(i);
        end
    end

    assign hit      = |match;
    assign train_id = hit ? hit_id : victim_id;

    // Store a new vector on a miss and refresh recency on every training.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld <= '0;
            for (int i = 0; i < D; i++) begin
                age[i]  <= IDW'(D - 1 - i);
                vecs[i] <= '0;
            end
        end else if (train) begin
            if (!hit) begin
                vecs[victim_id] <= vec_in;
                vld[victim_id]  <= 1'b1;
            end
            for (int i = 0; i < D; i++) begin
                if (IDW'(i) == train_id)         age[i] <= '0;
                else if (age[i] < age[train_id]) age[i] <= age[i] + 1'b1;
            end
        end
    end

    // Read one delta of a stored vector.
    assign rd_delta = vecs[rd_id][rd_pos*DW +: DW];

    AST_MATCH_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match));                                   // R5
    AST_ONE_OLDEST: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(oldest) == 1);                           // R6
    AST_TRAIN_MRU: assert property (@(posedge clk) disable iff (!rst_n)
        train |=> age[$past(train_id)] == '0);              // R6
endmodule

// File: rtl/dhp_pht.sv
// Module: identifier history and pattern table.
// Holds the last X identifiers, newest in the low bits, and a table indexed
// by that history. Each entry is a valid bit and the identifier that
// followed. Training writes the entry for the old history, then shifts.
// Assumes: the table has 2^(X*IDW) entries and IDW is small.
module dhp_pht #(
    parameter int unsigned IDW = 2,
    parameter int unsigned X   = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           train,
    input  logic [IDW-1:0] train_id,
    output logic           look_vld,
    output logic [IDW-1:0] look_id
);
    localparam int unsigned HW    = X * IDW;
    localparam int unsigned DEPTH = 1 << HW;

    logic [HW-1:0]    hist;
    logic [HW-1:0]    hist_nxt;
    logic [DEPTH-1:0] ent_vld;
    logic [IDW-1:0]   ent_id [DEPTH];

    // Next history: a depth of one keeps only the newest identifier.
    if (X == 1) begin : g_h1
        assign hist_nxt = train_id;
    end else begin : g_hn
        assign hist_nxt = {hist[HW-IDW-1:0], train_id};
    end

    // Train the entry for the old history, then shift the history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist    <= '0;
            ent_vld <= '0;
            for (int i = 0; i < DEPTH; i++) ent_id[i] <= '0;
        end else if (train) begin
            ent_vld[hist] <= 1'b1;
            ent_id[hist]  <= train_id;
            hist          <= hist_nxt;
        end
    end

    // Look up the entry for the current history.
    assign look_vld = ent_vld[hist];
    assign look_id  = ent_id[hist];

    AST_HIST_NEWEST: assert property (@(posedge clk) disable iff (!rst_n)
        train |=> hist[IDW-1:0] == $past(train_id));        // R5
    AST_TRAINED_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        train |=> ent_vld[$past(hist)]);                     // R5
endmodule

// File: rtl/dhp_stream.sv
// Module: prediction stream and previous address set.
// On go, runs NPOS beats and sums the stored previous set with the deltas
// of the predicted vector. The previous set is replaced when the caller
// accepts a task end.
// Assumes: go and set_we are never raised while busy.
module dhp_stream #(
    parameter int unsigned NPOS = 4,
    parameter int unsigned AW   = 32,
    parameter int unsigned IDW  = 2,
    parameter int unsigned PW   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [IDW-1:0]    go_id,
    input  logic              set_we,
    input  logic [NPOS*AW-1:0] set_in,
    input  logic [AW-1:0]     rd_delta,
    output logic              busy,
    output logic [IDW-1:0]    rd_id,
    output logic [PW-1:0]     rd_pos,
    output logic              pred_valid,
    output logic [PW-1:0]     pred_pos,
    output logic [AW-1:0]     pred_addr,
    output logic              pred_last
);
    localparam logic [PW-1:0] LAST = PW'(NPOS - 1);

    logic               busy_q;
    logic [PW-1:0]      pos_q;
    logic [IDW-1:0]     id_q;
    logic [NPOS*AW-1:0] prev_q;

    // Step the beat counter through one stream.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            pos_q  <= '0;
            id_q   <= '0;
        end else if (busy_q) begin
            if (pos_q == LAST) busy_q <= 1'b0;
            pos_q <= pos_q + 1'b1;
        end else if (go) begin
            busy_q <= 1'b1;
            pos_q  <= '0;
            id_q   <= go_id;
        end
    end

    // Keep the address set of the last finished task.
    always_ff @(posedge clk) begin
        if (!rst_n)      prev_q <= '0;
        else if (set_we) prev_q <= set_in;
    end

    assign busy       = busy_q;
    assign rd_id      = id_q;
    assign rd_pos     = pos_q;
    assign pred_valid = busy_q;
    assign pred_pos   = pos_q;
    assign pred_last  = busy_q && (pos_q == LAST);
    assign pred_addr  = prev_q[pos_q*AW +: AW] + rd_delta;

    AST_GO_FIRST_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        (go && !busy_q) |=> pred_valid && pred_pos == '0);   // R2
    AST_BEAT_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (pred_valid && !pred_last) |=>
            pred_valid && pred_pos == PW'($past(pred_pos) + 1'b1)); // R3
    AST_STOP_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        pred_last |=> !pred_valid);                           // R8
    AST_SET_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        pred_valid |-> !set_we);                              // R8
endmodule

// File: rtl/dhp_predictor.sv
// Module: top of the differential history pattern predictor.
// Gates the task strobes, then links the dictionary, the pattern table and
// the prediction stream. While a stream runs, both strobes are dropped. A
// start that meets an end in the same cycle is dropped.
// Assumes: D is a power of two, and end_diff/end_addrs are valid with task_end.
module dhp_predictor #(
    parameter int unsigned NPOS   = 4,
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned D      = 4,
    parameter int unsigned X      = 2,
    localparam int unsigned IDW   = dhp_pkg::idx_bits(D),
    localparam int unsigned POS_W = dhp_pkg::idx_bits(NPOS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   task_start,
    input  logic                   task_end,
    input  logic [NPOS*ADDR_W-1:0] end_diff,
    input  logic [NPOS*ADDR_W-1:0] end_addrs,
    output logic                   pred_valid,
    output logic [POS_W-1:0]       pred_pos,
    output logic [ADDR_W-1:0]      pred_addr,
    output logic                   pred_last
);
    logic             busy;
    logic             end_ok;
    logic             go;
    logic [IDW-1:0]   train_id;
    logic             look_vld;
    logic [IDW-1:0]   look_id;
    logic [IDW-1:0]   rd_id;
    logic [POS_W-1:0] rd_pos;
    logic [ADDR_W-1:0] rd_delta;

    // Accept strobes only while idle; an end wins over a start.
    assign end_ok = task_end && !busy;
    assign go     = task_start && !task_end && !busy && look_vld;

    dhp_dict #(.NPOS(NPOS), .DW(ADDR_W), .D(D), .IDW(IDW), .PW(POS_W)) u_dict (
        .clk      (clk),
        .rst_n    (rst_n),
        .train    (end_ok),
        .vec_in   (end_diff),
        .train_id (train_id),
        .rd_id    (rd_id),
        .rd_pos   (rd_pos),
        .rd_delta (rd_delta)
    );

    dhp_pht #(.IDW(IDW), .X(X)) u_pht (
        .clk      (clk),
        .rst_n    (rst_n),
        .train    (end_ok),
        .train_id (train_id),
        .look_vld (look_vld),
        .look_id  (look_id)
    );

    dhp_stream #(.NPOS(NPOS), .AW(ADDR_W), .IDW(IDW), .PW(POS_W)) u_stream (
        .clk        (clk),
        .rst_n      (rst_n),
        .go         (go),
        .go_id      (look_id),
        .set_we     (end_ok),
        .set_in     (end_addrs),
        .rd_delta   (rd_delta),
        .busy       (busy),
        .rd_id      (rd_id),
        .rd_pos     (rd_pos),
        .pred_valid (pred_valid),
        .pred_pos   (pred_pos),
        .pred_addr  (pred_addr),
        .pred_last  (pred_last)
    );

    AST_NO_START_ON_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        (task_start && !busy && !look_vld) |=> !pred_valid);   // R2
    AST_START_END_CLASH: assert property (@(posedge clk) disable iff (!rst_n)
        (task_start && task_end && !busy) |=> !pred_valid);    // R9
endmodule

// File: tb/tb_dhp_predictor.sv
`timescale 1ns/1ps
module tb_dhp_predictor;
    localparam int NPOS = 4;
    localparam int AW   = 32;
    localparam int VW   = NPOS * AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          task_start = 1'b0;
    logic          task_end = 1'b0;
    logic [VW-1:0] end_diff = '0;
    logic [VW-1:0] end_addrs = '0;
    logic          pred_valid;
    logic [1:0]    pred_pos;
    logic [AW-1:0] pred_addr;
    logic          pred_last;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;
    logic [VW-1:0] prev_set = '0;

    always #2.5 clk = ~clk;

    dhp_predictor #(.NPOS(NPOS), .ADDR_W(AW), .D(4), .X(2)) dut (
        .clk(clk), .rst_n(rst_n), .task_start(task_start), .task_end(task_end),
        .end_diff(end_diff), .end_addrs(end_addrs), .pred_valid(pred_valid),
        .pred_pos(pred_pos), .pred_addr(pred_addr), .pred_last(pred_last));

    function automatic logic [VW-1:0] mk(input int a, input int b, input int c, input int d);
        return {d[AW-1:0], c[AW-1:0], b[AW-1:0], a[AW-1:0]};
    endfunction

    task automatic chk(input string req, input string what, input logic [63:0] act,
                       input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        prev_set = '0;
    endtask

    task automatic end_task(input logic [VW-1:0] v, input logic [VW-1:0] a);
        @(negedge clk);
        task_end = 1'b1; end_diff = v; end_addrs = a;
        @(negedge clk);
        task_end = 1'b0;
        prev_set = a;
    endtask

    // Pulse a start and check the full stream against prev_set + deltas.
    task automatic expect_pred(input string req, input logic [VW-1:0] v);
        @(negedge clk);
        task_start = 1'b1;
        @(negedge clk);
        task_start = 1'b0;
        for (int p = 0; p < NPOS; p++) begin
            chk(req, "valid", 64'(pred_valid), 64'd1);
            chk("R3", "pos", 64'(pred_pos), 64'(p));
            chk("R3", "last", 64'(pred_last), 64'(p == NPOS - 1));
            chk("R4", "addr", 64'(pred_addr), 64'(prev_set[p*AW +: AW] + v[p*AW +: AW]));
            @(negedge clk);
        end
        chk("R3", "valid after last", 64'(pred_valid), 64'd0);
    endtask

    task automatic expect_none(input string req);
        @(negedge clk);
        task_start = 1'b1;
        @(negedge clk);
        task_start = 1'b0;
        chk(req, "no stream", 64'(pred_valid), 64'd0);
        @(negedge clk);
        chk(req, "no stream later", 64'(pred_valid), 64'd0);
    endtask

    localparam logic [VW-1:0] VA = {32'd64, 32'd8, 32'd96, 32'd32};
    localparam logic [VW-1:0] VB = {32'd32, 32'd0, 32'hFFFF_FFFC, 32'd16};

    // R1, R2: reset state and empty table.
    task automatic t_reset();
        do_reset();
        @(negedge clk);
        chk("R1", "valid at reset", 64'(pred_valid), 64'd0);
        expect_none("R2");
    endtask

    // R10, R5, R7, R4: learn the A,A,B rhythm through a two-deep history.
    task automatic t_rhythm();
        do_reset();
        end_task(VA, mk(32'h1000, 32'h2000, 32'h3000, 32'h4000));
        end_task(VA, mk(32'h1020, 32'h2060, 32'h3008, 32'h4040));
        end_task(VB, mk(32'h1030, 32'h205C, 32'h3008, 32'h4060));
        end_task(VA, mk(32'h1050, 32'h20BC, 32'h3010, 32'h40A0));
        end_task(VA, mk(32'h1070, 32'h211C, 32'h3018, 32'h40E0));
        end_task(VB, mk(32'h1080, 32'h2118, 32'h3018, 32'h4100));
        expect_pred("R10", VA);                 // history (A,B) -> A
        end_task(VA, mk(32'h10A0, 32'h2178, 32'h3020, 32'h4140));
        expect_pred("R10", VA);                 // history (B,A) -> A
        end_task(VA, mk(32'h10C0, 32'h0000_0002, 32'h3028, 32'h4180));
        expect_pred("R10", VB);                 // history (A,A) -> B, wraps below 0
        chk("R4", "negative delta wrap", 64'(prev_set[AW +: AW] + VB[AW +: AW]),
            64'hFFFF_FFFE);
    endtask

    // R8: start and end pulses inside a running stream change nothing.
    task automatic t_busy();
        @(negedge clk);
        task_start = 1'b1;
        @(negedge clk);
        task_start = 1'b1; task_end = 1'b1;
        end_diff = mk(5, 6, 7, 8); end_addrs = mk(1, 1, 1, 1);
        chk("R8", "beat0", 64'(pred_pos), 64'd0);
        @(negedge clk);
        task_start = 1'b0; task_end = 1'b0;
        chk("R8", "not restarted", 64'(pred_pos), 64'd1);
        repeat (3) @(negedge clk);
        chk("R8", "ends once", 64'(pred_valid), 64'd0);
        expect_pred("R8", VB);                  // same state, same prediction
    endtask

    // R9: a start meeting an end is dropped; the end is taken.
    task automatic t_clash();
        @(negedge clk);
        task_start = 1'b1; task_end = 1'b1;
        end_diff = VB; end_addrs = mk(32'h500, 32'h600, 32'h700, 32'h800);
        @(negedge clk);
        task_start = 1'b0; task_end = 1'b0;
        prev_set = mk(32'h500, 32'h600, 32'h700, 32'h800);
        chk("R9", "no stream", 64'(pred_valid), 64'd0);
        @(negedge clk);
        chk("R9", "no stream later", 64'(pred_valid), 64'd0);
        expect_pred("R9", VA);                  // history (A,B) -> A, end was taken
    endtask

    // R6: least recently used eviction seen through a stale table entry.
    task automatic t_lru();
        logic [VW-1:0] v0, v1, v2, v3, v4, s;
        v0 = mk(1, 1, 1, 1); v1 = mk(2, 2, 2, 2); v2 = mk(3, 3, 3, 3);
        v3 = mk(4, 4, 4, 4); v4 = mk(9, 10, 11, 12);
        s  = mk(32'h100, 32'h200, 32'h300, 32'h400);
        do_reset();
        end_task(v0, s); end_task(v1, s); end_task(v2, s); end_task(v3, s);
        end_task(v0, s);                        // hit refreshes id0
        end_task(v4, s);                        // evicts id1 (v1)
        end_task(v0, s); end_task(v0, mk(32'h1000, 32'h2000, 32'h3000, 32'h4000));
        expect_pred("R6", v4);                  // entry (0,0) names id1, now v4
    endtask

    initial begin
        t_reset();
        t_rhythm();
        t_busy();
        t_clash();
        t_lru();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end
endmodule